// File: doc/BRIEF.md
# Countdown Timer Bank

This block holds four counters behind a small word-addressed register bus. Three of them count down and raise an interrupt when they underflow: channels A and B hold 16 bits and channel C holds 32 bits. Each has a load word, a live count word, a control word and an acknowledge word. A channel in reload mode programmed with N fires once every N+1 ticks. The fourth counter is a 40-bit up-counter with no interrupt. It is meant for timestamps and is read as a low word and a high word.

Counting is paced by two tick-enable strobes that arrive with the bus clock, a slow one and a fast one. Each down-counter chooses one of them through its control word. The up-counter always follows the fast strobe. Software sets the mode first, then writes the load word, then sets enable. It acknowledges an interrupt by writing any value to the channel's acknowledge word.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every load, count and control word reads zero, all interrupt lines are low, and the up-counter reads zero with counting disabled.
- R2: An enabled down-counter (control bit 7 set) decreases by one on each tick of its chosen strobe, which is the fast strobe when control bit 3 is set and the slow strobe otherwise. A disabled counter, or one with no tick, holds its count. The count word sits at channel offset 0x4.
- R3: With control bit 6 set (reload mode), a channel whose count is zero reloads its load value on the next tick and raises its interrupt. Loaded with N, it therefore underflows once every N+1 ticks.
- R4: With control bit 6 clear, an underflow wraps the count to all ones (0xFFFF for A and B, 0xFFFFFFFF for C) and still raises the interrupt.
- R5: A write to the load word (channel offset 0x0) sets both the load value and the live count in the same cycle, whether or not the channel is enabled. Writes to the count word are ignored.
- R6: irq[0], irq[1] and irq[2] belong to channels A, B and C. Each is a level that stays high until any value is written to that channel's acknowledge word (offset 0xC). If an acknowledge and an underflow fall in the same cycle, the line stays high.
- R7: Channel A is based at 0x00, B at 0x20 and C at 0x80. Only word-aligned addresses decode. A control word (offset 0x8) reads back bits 7, 6 and 3 and reads zero in every other bit. Channels A and B keep only the low 16 bits of a load write. Reads of the acknowledge word and of unmapped addresses return zero. Read data is valid in the same cycle as the read strobe.
- R8: The up-counter adds one on each fast tick while bit 8 of the high word (0x64) is set. Bits 31:0 of the count read at 0x60, and bit 8 of the 0x64 read returns the enable.
- R9: A read of 0x60 captures count bits 39:32 into a shadow register. Bits 7:0 of a 0x64 read return that shadow, not the live upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | Slow tick-enable strobe |
| tick_fast | input | 1 | Fast tick-enable strobe |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW (32) | Read data, zero when no read |
| irq | output | 3 | Interrupt levels of channels A, B and C |

## Verification
The reload path is tried with small load values, so that each underflow shows whether the period is N or N+1 ticks. Reload and free-wrap modes are both used on a 16-bit and on the 32-bit channel, which separates a wrong wrap value from a wrong width. An acknowledge is issued in the same cycle as an underflow to expose any ordering fault, and random writes, reads and tick patterns test every register against a bench model. A second, narrower instance lets the fast counter cross its low-word boundary, so the test can tell a captured upper byte from a live one.

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int NARROW_W    = 16,
  parameter int WIDE_W      = 32,
  parameter int FREE_W      = 40,
  parameter int EN_BIT      = 7,
  parameter int PER_BIT     = 6,
  parameter int FAST_BIT    = 3,
  parameter int FREE_EN_BIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_slow,
  input  logic          tick_fast,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic [2:0]    irq
);

  localparam int NCH  = 3;
  localparam int HI_W = FREE_W - DW;
  localparam logic [AW-1:0] FREE_LO = AW'('h60);
  localparam logic [AW-1:0] FREE_HI = AW'('h64);
  localparam logic [DW-1:0] CTRL_MASK =
    (DW'(1) << EN_BIT) | (DW'(1) << PER_BIT) | (DW'(1) << FAST_BIT);

  function automatic logic [AW-5:0] page_of(int i);
    case (i)
      0:       return (AW-4)'('h0);
      1:       return (AW-4)'('h2);
      default: return (AW-4)'('h8);
    endcase
  endfunction

  function automatic logic [DW-1:0] mask_of(int i);
    int w;
    w = (i == NCH-1) ? WIDE_W : NARROW_W;
    if (w >= DW) return '1;
    return (DW'(1) << w) - DW'(1);
  endfunction

  logic [DW-1:0] ld_q  [NCH];
  logic [DW-1:0] val_q [NCH];
  logic [DW-1:0] ctl_q [NCH];
  logic [NCH-1:0] irq_q, hit, run, uf, wld, wctl, wclr;

  logic [FREE_W-1:0] fcnt;
  logic              fen;
  logic [HI_W-1:0]   shadow;
  logic [DW-1:0]     hi_word;

  wire lo_rd = bus_rd && (bus_addr == FREE_LO);
  wire hi_wr = bus_wr && (bus_addr == FREE_HI);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      hit[i]  = (bus_addr[AW-1:4] == page_of(i)) && (bus_addr[1:0] == 2'b00);
      run[i]  = ctl_q[i][EN_BIT] && (ctl_q[i][FAST_BIT] ? tick_fast : tick_slow);
      uf[i]   = run[i] && (val_q[i] == '0);
      wld[i]  = bus_wr && hit[i] && (bus_addr[3:2] == 2'd0);
      wctl[i] = bus_wr && hit[i] && (bus_addr[3:2] == 2'd2);
      wclr[i] = bus_wr && hit[i] && (bus_addr[3:2] == 2'd3);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ld_q[i]  <= '0;
        val_q[i] <= '0;
        ctl_q[i] <= '0;
      end
      irq_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wld[i]) begin
          ld_q[i]  <= bus_wdata & mask_of(i);
          val_q[i] <= bus_wdata & mask_of(i);
        end else if (run[i]) begin
          if (uf[i]) val_q[i] <= ctl_q[i][PER_BIT] ? ld_q[i] : mask_of(i);
          else       val_q[i] <= val_q[i] - DW'(1);
        end
        if (wctl[i]) ctl_q[i] <= bus_wdata & CTRL_MASK;
        if (uf[i])        irq_q[i] <= 1'b1;
        else if (wclr[i]) irq_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt   <= '0;
      fen    <= 1'b0;
      shadow <= '0;
    end else begin
      if (hi_wr)            fen    <= bus_wdata[FREE_EN_BIT];
      if (fen && tick_fast) fcnt   <= fcnt + FREE_W'(1);
      if (lo_rd)            shadow <= fcnt[FREE_W-1:DW];
    end
  end

  always_comb begin
    hi_word              = '0;
    hi_word[HI_W-1:0]    = shadow;
    hi_word[FREE_EN_BIT] = fen;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      for (int i = 0; i < NCH; i++) begin
        if (hit[i]) begin
          case (bus_addr[3:2])
            2'd0:    bus_rdata = ld_q[i];
            2'd1:    bus_rdata = val_q[i];
            2'd2:    bus_rdata = ctl_q[i];
            default: bus_rdata = '0;
          endcase
        end
      end
      if (bus_addr == FREE_LO) bus_rdata = fcnt[DW-1:0];
      if (bus_addr == FREE_HI) bus_rdata = hi_word;
    end
  end

  assign irq = irq_q;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (irq_q == '0) && !fen); // R1

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[g] && !wld[g]) |=> $stable(val_q[g])); // R2
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && !uf[g] && !wld[g]) |=> (val_q[g] == $past(val_q[g]) - DW'(1))); // R2
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (uf[g] && ctl_q[g][PER_BIT] && !wld[g]) |=> (val_q[g] == $past(ld_q[g]))); // R3
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (uf[g] && !ctl_q[g][PER_BIT] && !wld[g]) |=> (val_q[g] == mask_of(g))); // R4
    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      wld[g] |=> (val_q[g] == ld_q[g])); // R5
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      uf[g] |=> irq[g]); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[g] && !wclr[g]) |=> irq[g]); // R6
  end

  AST_FREE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && tick_fast) |=> (fcnt == $past(fcnt) + FREE_W'(1))); // R8
  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> (shadow == $past(fcnt[FREE_W-1:DW]))); // R9

endmodule

// File: tb/sim_tick_timer_bank.sv
`timescale 1ns/1ps
module sim_tick_timer_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ts = 1'b0, tf = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  logic tf1 = 1'b0, wr1 = 1'b0, rd1 = 1'b0;
  logic [7:0]  addr1 = '0;
  logic [15:0] wd1 = '0;
  logic [15:0] rdata1;
  logic [2:0]  irq1;

  always #2 clk = ~clk;

  tick_timer_bank u0 (
    .clk(clk), .rst_n(rst_n), .tick_slow(ts), .tick_fast(tf),
    .bus_addr(addr), .bus_wdata(wd), .bus_wr(wr), .bus_rd(rd),
    .bus_rdata(rdata), .irq(irq));

  tick_timer_bank #(.DW(16), .WIDE_W(16), .FREE_W(24)) u1 (
    .clk(clk), .rst_n(rst_n), .tick_slow(1'b0), .tick_fast(tf1),
    .bus_addr(addr1), .bus_wdata(wd1), .bus_wr(wr1), .bus_rd(rd1),
    .bus_rdata(rdata1), .irq(irq1));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] m_ld [3];
  logic [31:0] m_val[3];
  logic [31:0] m_ctl[3];
  logic [2:0]  m_irq;
  logic [39:0] m_f;
  logic        m_fen;
  logic [7:0]  m_sh;
  logic [31:0] last_rd;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] base_of(int c);
    return (c == 0) ? 8'h00 : (c == 1) ? 8'h20 : 8'h80;
  endfunction

  function automatic logic [31:0] msk_of(int c);
    return (c == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    for (int c = 0; c < 3; c++)
      if (a[7:4] == base_of(c)[7:4] && a[1:0] == 2'b00)
        case (a[3:2])
          2'd0: return m_ld[c];
          2'd1: return m_val[c];
          2'd2: return m_ctl[c];
          default: return 32'h0;
        endcase
    if (a == 8'h60) return m_f[31:0];
    if (a == 8'h64) return {23'h0, m_fen, m_sh};
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a == 8'h60) return "R8 free low";
    if (a == 8'h64) return "R9 free high";
    case (a[3:2])
      2'd0: return "R5 load word";
      2'd1: return "R2 count word";
      default: return "R7 control/ack word";
    endcase
  endfunction

  task automatic model_update();
    for (int c = 0; c < 3; c++) begin
      logic hitc, tk, runc, ufc;
      hitc = wr && addr[7:4] == base_of(c)[7:4] && addr[1:0] == 2'b00;
      tk   = m_ctl[c][3] ? tf : ts;
      runc = m_ctl[c][7] && tk;
      ufc  = runc && m_val[c] == 0;
      if (hitc && addr[3:2] == 2'd0) begin
        m_ld[c] = wd & msk_of(c); m_val[c] = wd & msk_of(c);
      end else if (runc)
        m_val[c] = ufc ? (m_ctl[c][6] ? m_ld[c] : msk_of(c)) : m_val[c] - 1;
      if (hitc && addr[3:2] == 2'd2) m_ctl[c] = wd & 32'hC8;
      if (ufc) m_irq[c] = 1'b1;
      else if (hitc && addr[3:2] == 2'd3) m_irq[c] = 1'b0;
    end
    if (rd && addr == 8'h60) m_sh = m_f[39:32];
    if (m_fen && tf) m_f = m_f + 1;
    if (wr && addr == 8'h64) m_fen = wd[8];
  endtask

  task automatic step();
    #1;
    if (rd) begin
      last_rd = rdata;
      chk(rdata, exp_rd(addr), tag_of(addr));
    end
    chk({29'h0, irq}, {29'h0, m_irq}, "R6 irq levels");
    model_update();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic s = 0, input logic f = 0);
    addr = a; wd = d; wr = 1; rd = 0; ts = s; tf = f;
    step();
    wr = 0; ts = 0; tf = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a);
    addr = a; rd = 1; wr = 0; ts = 0; tf = 0;
    step();
    rd = 0;
  endtask

  task automatic idle(input int n, input logic s, input logic f);
    for (int i = 0; i < n; i++) begin
      ts = s; tf = f; wr = 0; rd = 0;
      step();
    end
    ts = 0; tf = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 3; c++) begin m_ld[c] = 0; m_val[c] = 0; m_ctl[c] = 0; end
    m_irq = 0; m_f = 0; m_fen = 0; m_sh = 0; last_rd = 0;

    repeat (3) @(negedge clk);
    rd = 1; addr = 8'h08; #1; chk(rdata, 32'h0, "R1 reset control A");
    addr = 8'h84; #1; chk(rdata, 32'h0, "R1 reset count C");
    addr = 8'h64; #1; chk(rdata, 32'h0, "R1 reset free high");
    chk({29'h0, irq}, 32'h0, "R1 reset irq");
    rd = 0;
    @(negedge clk); rst_n = 1;

    // R3 reload period on channel A, slow ticks
    wr_reg(8'h08, 32'h40);
    wr_reg(8'h00, 32'd3);
    wr_reg(8'h08, 32'hC0);
    idle(3, 1, 0);
    rd_reg(8'h04); chk(last_rd, 32'd0, "R3 count at zero after N ticks");
    chk({31'h0, irq[0]}, 32'd0, "R3 no irq before N+1 ticks");
    idle(1, 1, 0);
    chk({31'h0, irq[0]}, 32'd1, "R3 irq after N+1 ticks");
    rd_reg(8'h04); chk(last_rd, 32'd3, "R3 reloaded value");
    idle(2, 0, 1);
    rd_reg(8'h04); chk(last_rd, 32'd3, "R2 fast strobe ignored on slow channel");

    // R6 level hold, acknowledge, and collision
    idle(4, 0, 0);
    chk({31'h0, irq[0]}, 32'd1, "R6 irq held");
    wr_reg(8'h0C, 32'h0);
    chk({31'h0, irq[0]}, 32'd0, "R6 acknowledge clears");
    wr_reg(8'h00, 32'd0);
    wr_reg(8'h0C, 32'h5A, 1, 0);
    chk({31'h0, irq[0]}, 32'd1, "R6 underflow wins over acknowledge");
    wr_reg(8'h08, 32'h0);
    wr_reg(8'h0C, 32'h1);
    chk({31'h0, irq[0]}, 32'd0, "R6 acknowledge clears again");

    // R4 free-wrap on channels B and C
    wr_reg(8'h28, 32'h08);
    wr_reg(8'h20, 32'd1);
    wr_reg(8'h28, 32'h88);
    idle(2, 0, 1);
    rd_reg(8'h24); chk(last_rd, 32'h0000_FFFF, "R4 narrow wrap");
    chk({31'h0, irq[1]}, 32'd1, "R4 irq on wrap");
    wr_reg(8'h28, 32'h0);
    wr_reg(8'h80, 32'd0);
    wr_reg(8'h88, 32'h80);
    idle(1, 1, 0);
    rd_reg(8'h84); chk(last_rd, 32'hFFFF_FFFF, "R4 wide wrap");
    chk({31'h0, irq[2]}, 32'd1, "R4 irq C");
    wr_reg(8'h88, 32'h0);

    // R5 load sets count; count writes ignored
    wr_reg(8'h24, 32'h1234);
    rd_reg(8'h24); chk(last_rd, 32'h0000_FFFF, "R5 count write ignored");
    wr_reg(8'h00, 32'h0001_2345);
    rd_reg(8'h04); chk(last_rd, 32'h2345, "R5 load sets count");
    rd_reg(8'h00); chk(last_rd, 32'h2345, "R7 narrow load truncated");

    // R7 control readback and unmapped reads
    wr_reg(8'h88, 32'hFFFF_FFFF);
    rd_reg(8'h88); chk(last_rd, 32'h0000_00C8, "R7 control readback mask");
    wr_reg(8'h88, 32'h0);
    rd_reg(8'h8C); chk(last_rd, 32'h0, "R7 acknowledge reads zero");
    rd_reg(8'h45); chk(last_rd, 32'h0, "R7 unmapped reads zero");

    // R8 free counter
    wr_reg(8'h64, 32'h100);
    idle(10, 0, 1);
    rd_reg(8'h60); chk(last_rd, 32'd10, "R8 free count");
    rd_reg(8'h64); chk(last_rd, 32'h100, "R8 enable readback");

    // random mix checked against the model
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [7:0] a;
      k = $urandom % 14;
      a = (k < 12) ? base_of(k / 4) + 8'(4 * (k % 4)) : ((k == 12) ? 8'h60 : 8'h64);
      ts = 1'($urandom); tf = 1'($urandom); addr = a;
      wr = 0; rd = 0;
      if ($urandom % 4 == 0) begin
        wr = 1;
        wd = ($urandom % 2 == 0) ? ($urandom % 6) : $urandom;
        if (a[3:2] == 2'd2 && $urandom % 2 == 0) wd = wd | 32'h80;
      end else rd = 1;
      step();
    end
    wr = 0; rd = 0; ts = 0; tf = 0;

    // R9 shadow coherence on the narrow instance
    addr1 = 8'h64; wd1 = 16'h0100; wr1 = 1;
    @(posedge clk); @(negedge clk); wr1 = 0;
    tf1 = 1;
    for (int i = 0; i < 65534; i++) begin @(posedge clk); @(negedge clk); end
    tf1 = 0; addr1 = 8'h60; rd1 = 1; #1;
    chk({16'h0, rdata1}, 32'hFFFE, "R9 low before carry");
    @(posedge clk); @(negedge clk);
    rd1 = 0; tf1 = 1;
    for (int i = 0; i < 3; i++) begin @(posedge clk); @(negedge clk); end
    tf1 = 0; addr1 = 8'h64; rd1 = 1; #1;
    chk({16'h0, rdata1}, 32'h0100, "R9 high returns captured byte");
    @(posedge clk); @(negedge clk);
    addr1 = 8'h60; #1;
    chk({16'h0, rdata1}, 32'h0001, "R9 low after carry");
    @(posedge clk); @(negedge clk);
    addr1 = 8'h64; #1;
    chk({16'h0, rdata1}, 32'h0101, "R9 high after new capture");
    rd1 = 0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule